// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master with Streaming Reads

This block is a byte-wide SPI master that sits behind four bus-addressable registers in an 8-bit peripheral slot. The CPU writes a byte to the data register, and the block shifts it out on MOSI while it captures the reply from MISO. The captured byte is read back from the same register. A control register sets three things: which clock paces SCK (a divided system clock or an external clock input), whether reads of the data register also start a transfer, and a program-enable output for an on-card EEPROM. A fourth register drives the active-low chip select directly.

The streaming-read option is meant for block input. With it enabled, every read of the data register returns the byte that has just arrived and starts the next shift. During that shift MOSI sends all ones, so software needs no write between reads. The SPI mode is fixed. SCK idles low, MISO is sampled on the rising SCK edge, MOSI changes on the falling edge, and the most significant bit goes first.

Top module: `spi_slot_master`

## Requirements
- R1: After reset, the control register reads 0x00, the select register (offset 3) reads 0x01, cs_n_o is 1, pgm_en_o is 0 and sck_o is 0. Offset 2 always reads 0x00.
- R2: A write to the data register (offset 0) while idle starts an 8-bit transfer. The byte goes out MSB first on mosi_o. SCK idles low, MISO is sampled on the rising SCK edge and MOSI changes only on the falling edge.
- R3: A read of offset 0 returns the last complete byte received, with the first MISO bit as its MSB. That value changes only once per transfer, when the eighth bit has been captured. A read in the middle of a transfer returns the previous byte.
- R4: With control bit 1 (stream) at 0, a read of offset 0 starts no transfer. With it at 1, a read of offset 0 while idle starts a transfer that sends 0xFF.
- R5: Control bit 0 (clock select) chooses the SCK source. At 0, each SCK half-period is SLOW_DIV system clocks. At 1, each SCK half-period is one period of ext_clk_i, counted between its synchronized rising edges.
- R6: A change of the clock-select bit during a transfer does not affect that transfer. It takes effect from the next transfer.
- R7: Control bit 7 (done, read-only) is set when a transfer completes and cleared when the next one starts. Control bit 6 (busy, read-only) is 1 while a transfer is in progress.
- R8: A read or write of offset 0 during a transfer neither restarts nor alters the transfer, and no new transfer follows it.
- R9: Control bit 2 drives pgm_en_o. Writing 0x00 to the control register clears clock select, stream and program enable.
- R10: Bit 0 of the select register drives cs_n_o. Writing 1 deselects the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register offset |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ext_clk_i | input | 1 | External SCK source, asynchronous |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| cs_n_o | output | 1 | Active-low chip select |
| pgm_en_o | output | 1 | EEPROM program enable |

## Verification
If the shift counter is off by one, the device receives a wrong byte and the data register reads a rotated value as soon as the transfer ends. A stuck busy flag shows on the next control-register poll. If the done flag is latched wrongly, it reads wrong one cycle after busy drops. If the streaming start is decoded wrongly, either SCK pulses or the busy bit rises on a plain read, within a couple of cycles. If the clock-source latch is wrong, the transfer takes noticeably more or fewer cycles than the source in force when it started would give. If the received byte is published early, a read in mid-transfer returns partial data rather than the previous byte.

// File: rtl/spi_slot_pkg.sv
package spi_slot_pkg;

   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_CTRL = 2'd1,
      RA_GAP  = 2'd2,
      RA_SEL  = 2'd3
   } reg_addr_e;

   // control register bit positions
   localparam int CB_CLKSEL = 0;
   localparam int CB_STREAM = 1;
   localparam int CB_PGM    = 2;
   localparam int CB_BUSY   = 6;
   localparam int CB_DONE   = 7;

   typedef struct packed {
      logic pgm;
      logic stream;
      logic clksel;
   } ctrl_t;

endpackage

// File: rtl/spi_slot_regs.sv
module spi_slot_regs
   import spi_slot_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy,
   input  logic              fin,
   input  logic [DATA_W-1:0] rx_byte,
   output ctrl_t             ctrl,
   output logic              cs_n,
   output logic              start,
   output logic [DATA_W-1:0] tx_byte
);

   logic done_q;
   logic data_wr, data_rd;

   assign data_wr = wr_en && (addr == RA_DATA);
   assign data_rd = rd_en && (addr == RA_DATA) && ctrl.stream;
   assign start   = !busy && (data_wr || data_rd);
   assign tx_byte = data_wr ? wdata : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         cs_n   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         if (wr_en && addr == RA_CTRL) begin
            ctrl.clksel <= wdata[CB_CLKSEL];
            ctrl.stream <= wdata[CB_STREAM];
            ctrl.pgm    <= wdata[CB_PGM];
         end
         if (wr_en && addr == RA_SEL)
            cs_n <= wdata[0];
         if (start)
            done_q <= 1'b0;
         else if (fin)
            done_q <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         RA_DATA: rdata = rx_byte;
         RA_CTRL: begin
            rdata[CB_CLKSEL] = ctrl.clksel;
            rdata[CB_STREAM] = ctrl.stream;
            rdata[CB_PGM]    = ctrl.pgm;
            rdata[CB_BUSY]   = busy;
            rdata[CB_DONE]   = done_q;
         end
         RA_SEL:  rdata[0] = cs_n;
         default: rdata = '0;
      endcase
   end

   // R9
   pgm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_CTRL) |=> (ctrl.pgm == $past(wdata[CB_PGM])));

   // R10
   cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_SEL) |=> (cs_n == $past(wdata[0])));

   // R7
   done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !start) |=> done_q);

endmodule

// File: rtl/spi_slot_clksel.sv
module spi_slot_clksel #(
   parameter int SLOW_DIV    = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic sel_ext,
   input  logic start,
   input  logic busy,
   output logic tick
);

   localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   if (SLOW_DIV < 2) begin : g_bad_div
      $error("SLOW_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev;
   logic                   ext_rise;
   logic                   src_q;
   logic [DIV_W-1:0]       div_q;
   logic                   slow_tick;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q[s] <= 1'b0;
         else if (s == 0)
            sync_q[s] <= ext_clk;
         else
            sync_q[s] <= sync_q[(s > 0) ? s-1 : 0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev <= 1'b0;
         src_q    <= 1'b0;
         div_q    <= '0;
      end else begin
         ext_prev <= sync_q[SYNC_STAGES-1];
         if (start) begin
            src_q <= sel_ext;
            div_q <= '0;
         end else if (busy) begin
            if (slow_tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
      end
   end

   assign ext_rise  = sync_q[SYNC_STAGES-1] && !ext_prev;
   assign slow_tick = (div_q == DIV_W'(SLOW_DIV - 1));
   assign tick      = busy && !start && (src_q ? ext_rise : slow_tick);

   // R6
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(src_q));

endmodule

// File: rtl/spi_slot_shifter.sv
module spi_slot_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              fin,
   output logic [DATA_W-1:0] rx_byte
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '1;
         rx_q    <= '0;
         rx_byte <= '0;
         cnt_q   <= '0;
         sck     <= 1'b0;
         busy    <= 1'b0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            tx_q  <= tx_byte;
            cnt_q <= '0;
            sck   <= 1'b0;
            busy  <= 1'b1;
         end else if (busy && tick) begin
            if (!sck) begin
               sck   <= 1'b1;
               rx_q  <= {rx_q[DATA_W-2:0], miso};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(DATA_W - 1))
                  rx_byte <= {rx_q[DATA_W-2:0], miso};
            end else begin
               sck <= 1'b0;
               if (cnt_q == CNT_W'(DATA_W)) begin
                  busy <= 1'b0;
                  fin  <= 1'b1;
               end else begin
                  tx_q <= {tx_q[DATA_W-2:0], 1'b1};
               end
            end
         end
      end
   end

   assign mosi = tx_q[DATA_W-1];

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R2
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DATA_W));

   // R3
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sck && $past(busy)) |-> $stable(rx_byte));

endmodule

// File: rtl/spi_slot_master.sv
module spi_slot_master
   import spi_slot_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SLOW_DIV    = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              ext_clk_i,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic              cs_n_o,
   output logic              pgm_en_o
);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end

   ctrl_t             ctrl;
   logic              start, busy, fin, tick;
   logic [DATA_W-1:0] tx_byte, rx_byte;

   spi_slot_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr_i),
      .wr_en   (wr_en_i),
      .rd_en   (rd_en_i),
      .wdata   (wdata_i),
      .rdata   (rdata_o),
      .busy    (busy),
      .fin     (fin),
      .rx_byte (rx_byte),
      .ctrl    (ctrl),
      .cs_n    (cs_n_o),
      .start   (start),
      .tx_byte (tx_byte)
   );

   spi_slot_clksel #(.SLOW_DIV(SLOW_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clksel (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ext_clk_i),
      .sel_ext (ctrl.clksel),
      .start   (start),
      .busy    (busy),
      .tick    (tick)
   );

   spi_slot_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_byte (tx_byte),
      .tick    (tick),
      .miso    (miso_i),
      .sck     (sck_o),
      .mosi    (mosi_o),
      .busy    (busy),
      .fin     (fin),
      .rx_byte (rx_byte)
   );

   assign pgm_en_o = ctrl.pgm;

   // R4
   plain_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_en_i && !wr_en_i && !ctrl.stream) |=> !busy);

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin && $past(busy)) |-> !start);

endmodule

// File: tb/test_spi_slot_master.sv
`timescale 1ns/1ps
module test_spi_slot_master;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       ext_clk = 1'b0;
   logic       sck, mosi, miso, cs_n, pgm_en;

   int errs = 0, checks = 0;

   always #2.5 clk = ~clk;
   always #10 ext_clk = ~ext_clk;

   spi_slot_master i_spi_slot_master (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
      .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext_clk), .sck_o(sck),
      .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .pgm_en_o(pgm_en)
   );

   // simple mode-0 slave
   logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
   int         s_idx = 0;
   int         sck_rises = 0;
   assign miso = (s_idx < 8) ? s_tx[7 - s_idx] : 1'b1;
   always @(posedge sck) begin
      s_rx <= {s_rx[6:0], mosi};
      sck_rises++;
   end
   always @(negedge sck) s_idx++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic slave_load(input logic [7:0] b);
      s_tx = b; s_idx = 0; sck_rises = 0;
   endtask

   task automatic wait_idle(output int cyc);
      logic [7:0] d;
      int n = 0;
      do begin
         bus_rd(2'd1, d); n++;
      end while (d[6] && n < 3000);
      cyc = 2 * n;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      bus_rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
      bus_rd(2'd3, d); chk("R1 sel", d, 8'h01);
      bus_rd(2'd2, d); chk("R1 gap", d, 8'h00);
      chk("R1 pins", {cs_n, pgm_en, sck}, 3'b100);
   endtask

   task automatic t_select;
      logic [7:0] d;
      bus_wr(2'd3, 8'h00); #1 chk("R10 cs low", cs_n, 1'b0);
      bus_wr(2'd3, 8'h01); #1 chk("R10 cs high", cs_n, 1'b1);
      bus_wr(2'd3, 8'h00);
      bus_wr(2'd2, 8'hFF); bus_rd(2'd2, d); chk("R1 gap after write", d, 8'h00);
   endtask

   task automatic t_slow_write;
      logic [7:0] d; int cyc;
      slave_load(8'h3C);
      bus_wr(2'd0, 8'hA5);
      bus_rd(2'd1, d); chk("R7 busy set done clear", d[7:6], 2'b01);
      wait_idle(cyc);
      chk("R2 mosi byte", s_rx, 8'hA5);
      chk("R2 eight clocks", sck_rises, 8);
      chk("R5 slow duration", (cyc >= 224 && cyc < 260), 1);
      bus_rd(2'd1, d); chk("R7 done", d[7:6], 2'b10);
      bus_rd(2'd0, d); chk("R3 rx byte", d, 8'h3C);
      chk("R2 sck idle", sck, 1'b0);
   endtask

   task automatic t_fast;
      logic [7:0] d; int cyc;
      bus_wr(2'd1, 8'h01);
      slave_load(8'hE7);
      bus_wr(2'd0, 8'h96);
      wait_idle(cyc);
      chk("R5 fast mosi", s_rx, 8'h96);
      bus_rd(2'd0, d); chk("R5 fast rx", d, 8'hE7);
      chk("R5 fast duration", (cyc >= 60 && cyc < 90), 1);
      bus_wr(2'd1, 8'h00);
   endtask

   task automatic t_switch_mid;
      int cyc;
      slave_load(8'h00);
      bus_wr(2'd0, 8'h0F);
      bus_wr(2'd1, 8'h01);
      wait_idle(cyc);
      chk("R6 slow kept", (cyc >= 215), 1);
      chk("R6 data", s_rx, 8'h0F);
      slave_load(8'h00);
      bus_wr(2'd0, 8'hF0);
      wait_idle(cyc);
      chk("R6 fast next", (cyc < 90), 1);
      bus_wr(2'd1, 8'h00);
   endtask

   task automatic t_busy_access;
      logic [7:0] d; int cyc;
      slave_load(8'h11);
      bus_wr(2'd0, 8'h5A);
      repeat (60) @(negedge clk);
      bus_rd(2'd0, d); chk("R3 mid-transfer read", d, 8'h00);
      bus_wr(2'd0, 8'h77);
      wait_idle(cyc);
      chk("R8 tx unchanged", s_rx, 8'h5A);
      chk("R8 eight clocks", sck_rises, 8);
      bus_rd(2'd0, d); chk("R8 rx", d, 8'h11);
      repeat (10) @(negedge clk);
      bus_rd(2'd1, d); chk("R8 no new transfer", d[6], 1'b0);
   endtask

   task automatic t_plain_read;
      logic [7:0] d;
      slave_load(8'h00);
      bus_rd(2'd0, d);
      repeat (20) @(negedge clk);
      bus_rd(2'd1, d); chk("R4 no start busy", d[6], 1'b0);
      chk("R4 no sck", sck_rises, 0);
   endtask

   task automatic t_stream;
      logic [7:0] d; int cyc;
      bus_wr(2'd1, 8'h02);
      slave_load(8'hC3);
      bus_rd(2'd0, d); chk("R4 stream returns last", d, 8'h11);
      wait_idle(cyc);
      chk("R4 sends FF", s_rx, 8'hFF);
      slave_load(8'h81);
      bus_rd(2'd0, d); chk("R4 stream next", d, 8'hC3);
      wait_idle(cyc);
      bus_wr(2'd1, 8'h00);
      bus_rd(2'd0, d); chk("R4 last byte", d, 8'h81);
   endtask

   task automatic t_ctrl_clear;
      logic [7:0] d;
      bus_wr(2'd1, 8'h07);
      #1 chk("R9 pgm on", pgm_en, 1'b1);
      bus_rd(2'd1, d); chk("R9 bits set", d[2:0], 3'b111);
      bus_wr(2'd1, 8'h00);
      #1 chk("R9 pgm off", pgm_en, 1'b0);
      bus_rd(2'd1, d); chk("R9 bits clear", d[2:0], 3'b000);
   endtask

   initial begin
      #(200000 * 5);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select();
      t_slow_write();
      t_fast();
      t_switch_mid();
      t_busy_access();
      t_plain_read();
      t_stream();
      t_ctrl_clear();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule